// File: doc/BRIEF.md
# Global Trigger Decision and Dispatch

This block collects fast trigger primitives from a set of detector towers and from the high-threshold lines of an anticoincidence shield, decides each clock cycle whether an event is accepted, and for every accepted event emits a one-cycle accept strobe together with a message word. The message names the processor that will own the event, and carries the arrival timestamp, a running event number and the set of trigger conditions that fired. Processors are chosen in rotation, and any processor that reports itself busy is passed over.

Each tower supplies one bit per tracker layer. A tower primitive fires when three adjacent layers of that tower are hit. The calorimeter supplies a low and a high discriminator line per tower. The shield supplies heavy-nucleus lines that pass through a per-channel mask before they are ORed together. An external trigger line completes the set of five conditions. A small register port sets the shield mask and the per-condition enables.

After each accept the block refuses new triggers for a fixed hold-off window. It also refuses them while the downstream path signals flow control, or while every processor is busy. Each cycle spent refusing adds one to a dead-time counter.

Top module: `gtrig_top`

## Requirements
- R1: Out of reset, `acc_o` is 0, `dead_time_o` is 0 and `msg_o` is 0. The shield mask clears to "all channels pass" and all five enables are set.
- R2: Condition bit 0 (tracker) is set when one tower has three adjacent layer bits set, where tower t, layer l is bit t*N_LAYER+l of `tkr_layer_i`. Two adjacent layers do not set it, and neither does a run of three that spans two towers.
- R3: Condition bit 1 is the OR of `cal_lo_i`, bit 2 is the OR of `cal_hi_i`, and bit 4 is `ext_trig_i`.
- R4: Condition bit 3 is the OR of the `cno_i` lines whose mask bit is 0. Writing address 0 loads the mask from the low N_SHIELD data bits, and a mask bit of 1 blocks its channel from the following cycle on.
- R5: Writing address 1 loads the enables from data bits 4:0. Only enabled condition bits count toward an accept and appear in the type field. An event is accepted when at least one enabled bit is set.
- R6: `acc_o` is high for exactly the one cycle after the cycle in which the trigger was accepted. `msg_o` is valid in that same cycle, with the type in bits 4:0, the event number in 20:5, the timestamp in 45:21 and the target in 47:46.
- R7: The event number of the first accept after reset is 0, and it increases by one with each accept only.
- R8: The timestamp is a free-running counter that is 0 at reset and increases by one each cycle. The message carries its value in the cycle the accept was decided.
- R9: After an accept, no further accept is decided in the next 8 cycles. With triggers held on, accepts therefore come 9 cycles apart.
- R10: While `flow_hold_i` is high, no accept is decided.
- R11: The target is the first processor without its `cpu_busy_i` bit set, searching upward (with wrap) from the processor after the last target. The search starts at processor 0 after reset. When all processors are busy, no accept is decided.
- R12: `dead_time_o` increases by one in every cycle in which an accept is blocked by hold-off, flow control or all processors busy, whether or not a trigger is present. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tkr_layer_i | input | N_TOWER*N_LAYER | Tracker layer hit bits per tower |
| cal_lo_i | input | N_TOWER | Calorimeter low discriminator per tower |
| cal_hi_i | input | N_TOWER | Calorimeter high discriminator per tower |
| cno_i | input | N_SHIELD | Shield heavy-nucleus lines |
| ext_trig_i | input | 1 | External / solicited trigger |
| flow_hold_i | input | 1 | Downstream flow control, blocks triggers |
| cpu_busy_i | input | N_CPU | Per-processor busy |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register address (0 mask, 1 enables) |
| reg_wdata_i | input | REG_DW | Register write data |
| acc_o | output | 1 | Trigger accept strobe |
| msg_o | output | MSG_W | Trigger message word |
| dead_time_o | output | DEAD_W | Dead-time cycle counter |

## Verification
A wrong rotation pointer shows up in the target field of the very next accept. A wrong event counter or timestamp counter shows up in the next message, and the error stays visible in every message after it. A hold-off counter that is off by one moves the spacing of accepts under a held trigger, and it also changes the dead-time count within one window. A stale mask or enable register shows up as a missing or extra strobe in the cycle after the triggering input.

// File: rtl/gtrig_pkg.sv
package gtrig_pkg;
   localparam int TYPE_W = 5;
   typedef enum int {
      TB_TKR = 0,
      TB_CLO = 1,
      TB_CHI = 2,
      TB_CNO = 3,
      TB_EXT = 4
   } tbit_e;
endpackage

// File: rtl/gtrig_prim.sv
module gtrig_prim
   import gtrig_pkg::*;
#(
   parameter int N_TOWER  = 16,
   parameter int N_LAYER  = 18,
   parameter int N_SHIELD = 12
) (
   input  logic [N_TOWER*N_LAYER-1:0] tkr_layer_i,
   input  logic [N_TOWER-1:0]         cal_lo_i,
   input  logic [N_TOWER-1:0]         cal_hi_i,
   input  logic [N_SHIELD-1:0]        cno_i,
   input  logic [N_SHIELD-1:0]        cno_mask_i,
   input  logic                       ext_i,
   output logic [TYPE_W-1:0]          raw_o
);
   localparam int RUN = 3;

   logic [N_TOWER-1:0] tower_hit;

   generate
      if (N_LAYER < RUN) begin : g_bad_layers
         $error("gtrig_prim: N_LAYER must be at least 3");
      end
   endgenerate

   genvar t, j;
   generate
      for (t = 0; t < N_TOWER; t++) begin : g_tower
         logic [N_LAYER-RUN:0] trip;
         for (j = 0; j <= N_LAYER - RUN; j++) begin : g_run
            assign trip[j] = &tkr_layer_i[t*N_LAYER + j +: RUN];
         end
         assign tower_hit[t] = |trip;
      end
   endgenerate

   always_comb begin
      raw_o         = '0;
      raw_o[TB_TKR] = |tower_hit;
      raw_o[TB_CLO] = |cal_lo_i;
      raw_o[TB_CHI] = |cal_hi_i;
      raw_o[TB_CNO] = |(cno_i & ~cno_mask_i);
      raw_o[TB_EXT] = ext_i;
   end
endmodule

// File: rtl/gtrig_gate.sv
module gtrig_gate #(
   parameter int HOLD_CYC = 8,
   parameter int DEAD_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              want_i,
   input  logic              flow_i,
   input  logic              none_free_i,
   output logic              fire_o,
   output logic [DEAD_W-1:0] dead_o
);
   localparam int HOLD_W = $clog2(HOLD_CYC + 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("gtrig_gate: HOLD_CYC must be positive");
      end
   endgenerate

   logic [HOLD_W-1:0] hold_q;
   logic [DEAD_W-1:0] dead_q;
   logic              blocked;

   assign blocked = flow_i | none_free_i | (hold_q != '0);
   assign fire_o  = want_i & ~blocked;
   assign dead_o  = dead_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         dead_q <= '0;
      end else begin
         if (fire_o)
            hold_q <= HOLD_W'(HOLD_CYC);
         else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
         if (blocked)
            dead_q <= dead_q + 1'b1;
      end
   end

   // checker-side gap counter, saturating at HOLD_CYC
   logic [HOLD_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= HOLD_W'(HOLD_CYC);
      else if (fire_o)
         gap_q <= '0;
      else if (gap_q != HOLD_W'(HOLD_CYC))
         gap_q <= gap_q + 1'b1;
   end

   // R9
   hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> gap_q == HOLD_W'(HOLD_CYC));
   // R10
   flow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_i |-> !fire_o);
   // R12
   dead_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_i || none_free_i) |=> dead_o == $past(dead_o) + DEAD_W'(1));
   // R12
   dead_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> $stable(dead_o));
endmodule

// File: rtl/gtrig_disp.sv
module gtrig_disp
   import gtrig_pkg::*;
#(
   parameter int N_CPU = 4,
   parameter int TS_W  = 25,
   parameter int EVN_W = 16,
   localparam int TGT_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
   localparam int MSG_W = TGT_W + TS_W + EVN_W + TYPE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [TYPE_W-1:0] type_i,
   input  logic [N_CPU-1:0]  busy_i,
   output logic              none_free_o,
   output logic              acc_o,
   output logic [MSG_W-1:0]  msg_o
);
   generate
      if (N_CPU < 2) begin : g_bad_cpu
         $error("gtrig_disp: N_CPU must be at least 2");
      end
   endgenerate

   logic [TGT_W-1:0] ptr_q;
   logic [TGT_W-1:0] tgt_c;
   logic [N_CPU-1:0] grant;
   logic             found;
   logic [TS_W-1:0]  ts_q;
   logic [EVN_W-1:0] evn_q;
   logic             acc_q;
   logic [MSG_W-1:0] msg_q;

   always_comb begin
      grant = '0;
      tgt_c = '0;
      found = 1'b0;
      for (int k = 0; k < N_CPU; k++) begin
         int idx;
         idx = (int'(ptr_q) + k) % N_CPU;
         if (!found && !busy_i[idx]) begin
            found      = 1'b1;
            grant[idx] = 1'b1;
            tgt_c      = TGT_W'(idx);
         end
      end
   end

   assign none_free_o = ~found;
   assign acc_o       = acc_q;
   assign msg_o       = msg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         ts_q  <= '0;
         evn_q <= '0;
         acc_q <= 1'b0;
         msg_q <= '0;
      end else begin
         ts_q  <= ts_q + 1'b1;
         acc_q <= fire_i;
         if (fire_i) begin
            msg_q <= {tgt_c, ts_q, evn_q, type_i};
            evn_q <= evn_q + 1'b1;
            ptr_q <= (int'(tgt_c) == N_CPU - 1) ? '0 : tgt_c + 1'b1;
         end
      end
   end

   // R8
   ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ts_q == $past(ts_q) + TS_W'(1));
   // R7
   evn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_i |=> $stable(evn_q));
   // R7
   evn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> evn_q == $past(evn_q) + EVN_W'(1));
   // R11
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & busy_i) == '0));
   // R6
   acc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |=> !acc_o || $past(fire_i));
endmodule

// File: rtl/gtrig_top.sv
module gtrig_top
   import gtrig_pkg::*;
#(
   parameter int N_TOWER  = 16,
   parameter int N_LAYER  = 18,
   parameter int N_SHIELD = 12,
   parameter int N_CPU    = 4,
   parameter int TS_W     = 25,
   parameter int EVN_W    = 16,
   parameter int DEAD_W   = 32,
   parameter int HOLD_CYC = 8,
   parameter int REG_AW   = 2,
   parameter int REG_DW   = 32,
   localparam int TGT_W   = (N_CPU > 1) ? $clog2(N_CPU) : 1,
   localparam int MSG_W   = TGT_W + TS_W + EVN_W + TYPE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_TOWER*N_LAYER-1:0] tkr_layer_i,
   input  logic [N_TOWER-1:0]         cal_lo_i,
   input  logic [N_TOWER-1:0]         cal_hi_i,
   input  logic [N_SHIELD-1:0]        cno_i,
   input  logic                       ext_trig_i,
   input  logic                       flow_hold_i,
   input  logic [N_CPU-1:0]           cpu_busy_i,
   input  logic                       reg_we_i,
   input  logic [REG_AW-1:0]          reg_addr_i,
   input  logic [REG_DW-1:0]          reg_wdata_i,
   output logic                       acc_o,
   output logic [MSG_W-1:0]           msg_o,
   output logic [DEAD_W-1:0]          dead_time_o
);
   localparam logic [REG_AW-1:0] A_MASK = REG_AW'(0);
   localparam logic [REG_AW-1:0] A_EN   = REG_AW'(1);

   generate
      if (N_SHIELD > REG_DW || TYPE_W > REG_DW) begin : g_bad_reg
         $error("gtrig_top: register data too narrow");
      end
      if (REG_AW < 1) begin : g_bad_aw
         $error("gtrig_top: REG_AW must be positive");
      end
   endgenerate

   logic [N_SHIELD-1:0] mask_q;
   logic [TYPE_W-1:0]   en_q;
   logic [TYPE_W-1:0]   raw_c;
   logic [TYPE_W-1:0]   type_c;
   logic                fire;
   logic                none_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= '1;
      end else if (reg_we_i) begin
         if (reg_addr_i == A_MASK) mask_q <= reg_wdata_i[N_SHIELD-1:0];
         if (reg_addr_i == A_EN)   en_q   <= reg_wdata_i[TYPE_W-1:0];
      end
   end

   gtrig_prim #(
      .N_TOWER (N_TOWER),
      .N_LAYER (N_LAYER),
      .N_SHIELD(N_SHIELD)
   ) u_prim (
      .tkr_layer_i(tkr_layer_i),
      .cal_lo_i   (cal_lo_i),
      .cal_hi_i   (cal_hi_i),
      .cno_i      (cno_i),
      .cno_mask_i (mask_q),
      .ext_i      (ext_trig_i),
      .raw_o      (raw_c)
   );

   assign type_c = raw_c & en_q;

   gtrig_gate #(
      .HOLD_CYC(HOLD_CYC),
      .DEAD_W  (DEAD_W)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .want_i     (|type_c),
      .flow_i     (flow_hold_i),
      .none_free_i(none_free),
      .fire_o     (fire),
      .dead_o     (dead_time_o)
   );

   gtrig_disp #(
      .N_CPU(N_CPU),
      .TS_W (TS_W),
      .EVN_W(EVN_W)
   ) u_disp (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire),
      .type_i     (type_c),
      .busy_i     (cpu_busy_i),
      .none_free_o(none_free),
      .acc_o      (acc_o),
      .msg_o      (msg_o)
   );

   // R5
   type_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |-> msg_o[TYPE_W-1:0] != '0);
   // R11
   all_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cpu_busy_i) |=> !acc_o);
endmodule

// File: tb/gtrig_top_test.sv
`timescale 1ns/1ps
module gtrig_top_test;
   localparam int NT = 16, NL = 18, NS = 12, NC = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic [NT*NL-1:0] tkr = '0;
   logic [NT-1:0] clo = '0, chi = '0;
   logic [NS-1:0] cno = '0;
   logic ext = 0, flow = 0;
   logic [NC-1:0] busy = '0;
   logic we = 0;
   logic [1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic acc;
   logic [47:0] msg;
   logic [31:0] dead;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gtrig_top uut (
      .clk(clk), .rst_n(rst_n), .tkr_layer_i(tkr), .cal_lo_i(clo), .cal_hi_i(chi),
      .cno_i(cno), .ext_trig_i(ext), .flow_hold_i(flow), .cpu_busy_i(busy),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .acc_o(acc), .msg_o(msg), .dead_time_o(dead));

   // behavioural reference model
   int m_ts, m_evn, m_hold, m_ptr;
   longint m_dead;
   bit e_acc;
   logic [47:0] e_msg;
   logic [NS-1:0] m_mask;
   logic [4:0] m_en;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ts = 0; m_evn = 0; m_hold = 0; m_ptr = 0; m_dead = 0;
         e_acc = 0; e_msg = '0; m_mask = '0; m_en = 5'h1F;
      end else begin
         logic [4:0] ty;
         bit fnd, blk;
         int tg;
         ty = '0;
         for (int t = 0; t < NT; t++)
            for (int l = 0; l + 2 < NL; l++)
               if (tkr[t*NL+l] && tkr[t*NL+l+1] && tkr[t*NL+l+2]) ty[0] = 1;
         if (|clo) ty[1] = 1;
         if (|chi) ty[2] = 1;
         if (|(cno & ~m_mask)) ty[3] = 1;
         if (ext) ty[4] = 1;
         ty = ty & m_en;
         fnd = 0; tg = 0;
         for (int k = 0; k < NC; k++)
            if (!fnd && !busy[(m_ptr + k) % NC]) begin fnd = 1; tg = (m_ptr + k) % NC; end
         blk = (m_hold != 0) || flow || !fnd;
         e_acc = 0;
         if (!blk && ty != 0) begin
            e_acc = 1;
            e_msg = {2'(tg), 25'(m_ts), 16'(m_evn), ty};
            m_evn = (m_evn + 1) % 65536;
            m_ptr = (tg + 1) % NC;
            m_hold = 8;
         end else if (m_hold > 0) m_hold--;
         if (blk) m_dead++;
         m_ts = (m_ts + 1) % (1 << 25);
         if (we) begin
            if (addr == 0) m_mask = wdata[NS-1:0];
            if (addr == 1) m_en = wdata[4:0];
         end
      end
   end

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 accept strobe", 64'(acc), 64'(e_acc));
         check("R12 dead time", 64'(dead), 64'(m_dead[31:0]));
         if (e_acc) begin
            check("R5 type field", 64'(msg[4:0]), 64'(e_msg[4:0]));
            check("R7 event number", 64'(msg[20:5]), 64'(e_msg[20:5]));
            check("R8 timestamp", 64'(msg[45:21]), 64'(e_msg[45:21]));
            check("R11 target", 64'(msg[47:46]), 64'(e_msg[47:46]));
         end
      end
   end

   task automatic clear_in();
      tkr = '0; clo = '0; chi = '0; cno = '0; ext = 0;
   endtask

   task automatic settle();
      clear_in();
      repeat (10) @(negedge clk);
   endtask

   // present a one-cycle trigger, then check the strobe and type one cycle later
   task automatic pulse_expect(string tag, bit exp_acc, logic [4:0] exp_ty);
      @(negedge clk);
      clear_in();
      check(tag, 64'(acc), 64'(exp_acc));
      if (exp_acc) check(tag, 64'(msg[4:0]), 64'(exp_ty));
      settle();
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      we = 1; addr = a; wdata = d;
      @(negedge clk);
      we = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      clear_in(); flow = 0; busy = '0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      logic [31:0] d0;
      logic [24:0] ts0;
      int first, prev, n_acc;
      repeat (3) @(negedge clk);
      // R1
      check("R1 acc after reset", 64'(acc), 0);
      check("R1 dead after reset", 64'(dead), 0);
      check("R1 msg after reset", 64'(msg), 0);
      rst_n = 1;
      settle();

      // R2: three adjacent layers in tower 5
      @(negedge clk); tkr[5*NL+4] = 1; tkr[5*NL+5] = 1; tkr[5*NL+6] = 1;
      pulse_expect("R2 run of three", 1, 5'b00001);
      @(negedge clk); tkr[5*NL+4] = 1; tkr[5*NL+5] = 1; tkr[5*NL+7] = 1;
      pulse_expect("R2 broken run", 0, 0);
      @(negedge clk); tkr[2*NL+17] = 1; tkr[3*NL+0] = 1; tkr[3*NL+1] = 1;
      pulse_expect("R2 run across towers", 0, 0);

      // R3
      @(negedge clk); chi[15] = 1;
      pulse_expect("R3 cal high", 1, 5'b00100);
      @(negedge clk); clo[0] = 1;
      pulse_expect("R3 cal low", 1, 5'b00010);
      @(negedge clk); ext = 1;
      pulse_expect("R3 external", 1, 5'b10000);

      // R4: mask shield channel 3
      wr(2'd0, 32'h8);
      @(negedge clk); cno[3] = 1;
      pulse_expect("R4 masked channel", 0, 0);
      @(negedge clk); cno[5] = 1;
      pulse_expect("R4 open channel", 1, 5'b01000);
      wr(2'd0, 32'h0);
      settle();

      // R5: only calorimeter low enabled
      wr(2'd1, 32'h2);
      settle();
      @(negedge clk); ext = 1;
      pulse_expect("R5 disabled type", 0, 0);
      @(negedge clk); ext = 1; clo[7] = 1;
      pulse_expect("R5 enabled only bits", 1, 5'b00010);
      wr(2'd1, 32'h1F);
      settle();

      // R6: strobe width one cycle
      @(negedge clk); ext = 1;
      @(negedge clk); clear_in();
      check("R6 strobe high", 64'(acc), 1);
      @(negedge clk);
      check("R6 strobe low next", 64'(acc), 0);
      settle();

      // R10 and R12: flow hold for five cycles
      d0 = dead;
      @(negedge clk); flow = 1; clo[3] = 1;
      @(negedge clk);
      check("R10 blocked by flow", 64'(acc), 0);
      repeat (4) @(negedge clk);
      check("R12 five dead cycles", 64'(dead - d0), 5);
      flow = 0;
      @(negedge clk); clear_in();
      check("R10 accept after release", 64'(acc), 1);
      settle();

      // R9: held trigger gives accepts nine cycles apart
      first = -1; prev = -1; n_acc = 0;
      @(negedge clk); ext = 1;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (acc) begin
            if (prev >= 0) check("R9 accept spacing", 64'(c - prev), 9);
            prev = c; n_acc++;
         end
      end
      check("R9 accept count", 64'(n_acc), 5);
      settle();

      // R11, R7, R8 from a fresh reset
      do_reset();
      settle();
      @(negedge clk); busy = 4'b0001; clo[1] = 1;
      @(negedge clk); clear_in();
      check("R11 skip busy cpu0", 64'(msg[47:46]), 1);
      check("R7 first event", 64'(msg[20:5]), 0);
      ts0 = msg[45:21];
      repeat (10) @(negedge clk);
      busy = 4'b0100; clo[1] = 1;
      @(negedge clk); clear_in();
      check("R11 skip busy cpu2", 64'(msg[47:46]), 3);
      check("R7 second event", 64'(msg[20:5]), 1);
      check("R8 timestamp gap", 64'(msg[45:21] - ts0), 11);
      repeat (10) @(negedge clk);
      busy = '0; clo[1] = 1;
      @(negedge clk); clear_in();
      check("R11 wrap to cpu0", 64'(msg[47:46]), 0);
      settle();
      busy = 4'b1111; ext = 1;
      @(negedge clk); clear_in();
      check("R11 all busy", 64'(acc), 0);
      busy = '0;
      settle();

      // mixed stimulus compared cycle by cycle with the model
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         clear_in();
         if ($urandom_range(3) == 0) tkr[$urandom_range(NT*NL-3) +: 3] = 3'b111;
         if ($urandom_range(5) == 0) clo[$urandom_range(NT-1)] = 1;
         if ($urandom_range(7) == 0) chi[$urandom_range(NT-1)] = 1;
         if ($urandom_range(5) == 0) cno[$urandom_range(NS-1)] = 1;
         if ($urandom_range(9) == 0) ext = 1;
         flow = ($urandom_range(7) == 0);
         busy = 4'($urandom_range(15));
         if ($urandom_range(3) != 0) busy = busy & 4'($urandom_range(15));
         we = ($urandom_range(29) == 0);
         addr = 2'($urandom_range(1));
         wdata = (addr == 0) ? 32'($urandom_range(4095)) : 32'($urandom_range(31));
      end
      @(negedge clk);
      we = 0; clear_in(); flow = 0; busy = '0;
      repeat (12) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule